// File: doc/BRIEF.md
# Masked address trap comparator

This block watches a stream of bus cycles and raises a one-clock trap pulse whenever a cycle lands inside a device window set up by software. Power-management logic uses the pulse to detect device activity. It also uses a companion countdown that flags expiry once the device has been quiet for a programmed number of clocks.

The window is defined by a 32-bit base address and an 8-bit control byte. The control byte has two meanings, chosen by its top bit. In I/O mode it carries two direction enables and a 5-bit mask over the lowest address bits. In memory mode it carries a 7-bit mask over address bits 15:9, which gives windows from 512 bytes to 64 KB. All configuration is loaded through a single write port with a 2-bit register select.

Top module: `addr_trap_unit`

## Requirements
- R1: A cycle can trap only when its space flag `cyc_is_mem` equals control bit 7 (0 = I/O window, 1 = memory window).
- R2: A control mask bit at 1 removes its address bit from the base comparison. Every address bit that is not masked and not ignored must equal the base bit.
- R3: In I/O mode, control bit 6 at 1 allows write cycles to trap and control bit 5 at 1 allows read cycles to trap. A 0 in either bit blocks that direction.
- R4: In I/O mode, control bits 4:0 mask address bits 4:0, address bits 15:5 are compared exactly, and address bits 31:16 are ignored.
- R5: In memory mode, control bits 6:0 mask address bits 15:9, address bits 8:0 are ignored, and address bits 31:16 are compared exactly.
- R6: In memory mode, read and write cycles both trap, whatever the values of control bits 6:5.
- R7: After reset, the base, control and idle reload registers are all 0, and both outputs are low. With this reset configuration, an I/O cycle at address 0 does not trap.
- R8: `trap_pulse` is high for exactly the one clock after a qualifying edge on which `cyc_valid` is high. A cycle with `cyc_valid` low never traps.
- R9: Each trap pulse reloads the idle counter from the reload register. `idle_expired` then pulses for one clock, N+2 clocks after the trap pulse rose, where N is the reload value. A new trap during the countdown restarts it.
- R10: Write select 0 loads the base from `cfg_wdata[31:0]`, select 1 loads control from `cfg_wdata[7:0]`, and select 2 loads the reload value from `cfg_wdata[15:0]`. A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| cyc_valid | input | 1 | Bus cycle present this clock |
| cyc_addr | input | 32 | Bus cycle address |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cyc_is_wr | input | 1 | 1 = write, 0 = read |
| trap_pulse | output | 1 | One-clock window hit pulse |
| idle_expired | output | 1 | One-clock idle timeout pulse |

## Verification
A trap is registered once, so it can be seen in the clock after the edge that samples the cycle. The bench drives each cycle on a falling edge and reads `trap_pulse` on the next falling edge. The idle flag has two more register stages: the counter reload and the expiry flop. The bench therefore counts falling edges from the trap pulse and expects the flag on count N+2, then expects it low again on the following edge. Configuration writes take effect on the edge that samples them, and each write is followed by a settling clock before cycles are driven.

// File: rtl/trap_pkg.sv
// Package: shared encodings for the address trap unit.
// Assumes: the write select is two bits wide.
package trap_pkg;
    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    localparam int CTRL_W   = 8;
    localparam int SPACE_B  = 7;
    localparam int WREN_B   = 6;
    localparam int RDEN_B   = 5;
    localparam int IO_MSK_W = 5;
    localparam int MEM_MSK_W = 7;
    localparam int MEM_LO   = 9;
    localparam int LOW_SPAN = 16;
endpackage

// File: rtl/trap_cfg_regs.sv
// Module: configuration registers loaded through one write port.
// Assumes: ADDR_W >= CNT_W and ADDR_W >= 8; writes land on the sampling edge.
module trap_cfg_regs
    import trap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  reload_q
);
    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    // Load the selected register; select 3 touches nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (cfg_we) begin
            case (sel)
                SEL_BASE:   base_q   <= cfg_wdata;
                SEL_CTRL:   ctrl_q   <= cfg_wdata[CTRL_W-1:0];
                SEL_RELOAD: reload_q <= cfg_wdata[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    // R10: select 3 leaves every register unchanged.
    p_sel_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd3) |=> ($stable(base_q) && $stable(ctrl_q) && $stable(reload_q)));
endmodule

// File: rtl/trap_match.sv
// Module: masked window compare and registered trap pulse.
// Assumes: ADDR_W > 16; control layout taken from trap_pkg.
module trap_match
    import trap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [CTRL_W-1:0] ctrl_q,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_is_mem,
    input  logic              cyc_is_wr,
    output logic              trap_pulse
);
    logic              mem_mode;
    logic [ADDR_W-1:0] care;
    logic              addr_ok;
    logic              dir_ok;
    logic              hit;

    assign mem_mode = ctrl_q[SPACE_B];

    // Per-bit care vector: which address bits take part in the compare.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_care
        if (i < IO_MSK_W) begin : g_lo
            assign care[i] = !mem_mode && !ctrl_q[i];
        end else if (i < MEM_LO) begin : g_io_only
            assign care[i] = !mem_mode;
        end else if (i < MEM_LO + MEM_MSK_W) begin : g_mid
            assign care[i] = mem_mode ? !ctrl_q[i-MEM_LO] : 1'b1;
        end else begin : g_hi
            assign care[i] = mem_mode;
        end
    end

    // Compare the address against the base and qualify the cycle direction.
    always_comb begin
        addr_ok = (((cyc_addr ^ base_q) & care) == '0);
        dir_ok  = mem_mode ? 1'b1 : (cyc_is_wr ? ctrl_q[WREN_B] : ctrl_q[RDEN_B]);
        hit     = cyc_valid && (cyc_is_mem == mem_mode) && addr_ok && dir_ok;
    end

    // Register the hit as a one-clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_pulse <= 1'b0;
        else        trap_pulse <= hit;
    end

    // R8: a pulse always follows a valid cycle.
    p_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> $past(cyc_valid));
    // R1: the space flag of the trapped cycle matched the mode bit.
    p_space_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> ($past(cyc_is_mem) == $past(ctrl_q[SPACE_B])));
    // R3: an I/O trap only for an enabled direction.
    p_io_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_pulse && !$past(ctrl_q[SPACE_B])) |->
        ($past(cyc_is_wr) ? $past(ctrl_q[WREN_B]) : $past(ctrl_q[RDEN_B])));
endmodule

// File: rtl/trap_idle_timer.sv
// Module: idle countdown reloaded by each trap, one-clock expiry pulse.
// Assumes: the counter is idle (disarmed) until the first trap.
module trap_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_pulse,
    input  logic [CNT_W-1:0] reload_q,
    output logic             idle_expired
);
    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Reload on trap, count down while armed, disarm at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (trap_pulse) begin
            cnt   <= reload_q;
            armed <= 1'b1;
        end else if (armed) begin
            if (cnt == '0) armed <= 1'b0;
            else           cnt   <= cnt - 1'b1;
        end
    end

    // Flag expiry for one clock when an armed count sits at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_expired <= 1'b0;
        else        idle_expired <= armed && (cnt == '0) && !trap_pulse;
    end

    // R9: a trap reloads the counter and arms it.
    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> (armed && cnt == $past(reload_q)));
    // R9: expiry lasts a single clock.
    p_expire_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_expired |=> !idle_expired);
endmodule

// File: rtl/addr_trap_unit.sv
// Module: top of the masked address trap comparator.
// Assumes: single clock domain, synchronous active-low reset.
module addr_trap_unit #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_is_mem,
    input  logic              cyc_is_wr,
    output logic              trap_pulse,
    output logic              idle_expired
);
    localparam int CW = trap_pkg::CTRL_W;

    logic [ADDR_W-1:0] base_q;
    logic [CW-1:0]     ctrl_q;
    logic [CNT_W-1:0]  reload_q;

    trap_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .base_q(base_q), .ctrl_q(ctrl_q), .reload_q(reload_q)
    );

    trap_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .base_q(base_q), .ctrl_q(ctrl_q),
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_is_mem(cyc_is_mem),
        .cyc_is_wr(cyc_is_wr), .trap_pulse(trap_pulse)
    );

    trap_idle_timer #(.CNT_W(CNT_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .trap_pulse(trap_pulse),
        .reload_q(reload_q), .idle_expired(idle_expired)
    );

    // R7: outputs are low in the clock after a reset edge.
    p_reset_quiet_r7: assert property (@(posedge clk)
        !rst_n |=> (!trap_pulse && !idle_expired));
endmodule

// File: tb/tb_addr_trap_unit.sv
module tb_addr_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        cyc_valid = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        cyc_is_mem = 1'b0;
    logic        cyc_is_wr = 1'b0;
    logic        trap_pulse;
    logic        idle_expired;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addr_trap_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_is_mem(cyc_is_mem), .cyc_is_wr(cyc_is_wr),
        .trap_pulse(trap_pulse), .idle_expired(idle_expired)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one cycle and check the trap one clock later.
    task automatic bus(input string req, input logic v, input logic [31:0] a,
                       input logic mem, input logic wr, input logic exp);
        @(negedge clk);
        cyc_valid = v; cyc_addr = a; cyc_is_mem = mem; cyc_is_wr = wr;
        @(negedge clk);
        cyc_valid = 1'b0;
        check(req, {31'b0, trap_pulse}, {31'b0, exp});
    endtask

    task automatic t_reset();
        check("R7 trap after reset", {31'b0, trap_pulse}, 32'd0);
        check("R7 idle after reset", {31'b0, idle_expired}, 32'd0);
        bus("R7 zero config io read", 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
        bus("R7 zero config io write", 1'b1, 32'h0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_io();
        wr_cfg(2'd0, 32'h0000_03F8);
        wr_cfg(2'd1, 32'h0000_0047);
        bus("R4 upper ignored, low masked", 1'b1, 32'hFFFF_03FF, 1'b0, 1'b1, 1'b1);
        bus("R8 single pulse", 1'b0, 32'h0000_03F8, 1'b0, 1'b1, 1'b0);
        bus("R8 invalid no trap", 1'b0, 32'h0000_03F8, 1'b0, 1'b1, 1'b0);
        bus("R3 read blocked", 1'b1, 32'h0000_03F8, 1'b0, 1'b0, 1'b0);
        bus("R2 unmasked bit3 differs", 1'b1, 32'h0000_03F0, 1'b0, 1'b1, 1'b0);
        bus("R4 bit10 exact", 1'b1, 32'h0000_07F8, 1'b0, 1'b1, 1'b0);
        bus("R1 memory cycle in io mode", 1'b1, 32'h0000_03F8, 1'b1, 1'b1, 1'b0);
        wr_cfg(2'd1, 32'h0000_0027);
        bus("R3 read enabled", 1'b1, 32'h0000_03FC, 1'b0, 1'b0, 1'b1);
        bus("R3 write blocked", 1'b1, 32'h0000_03FC, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_mem();
        wr_cfg(2'd0, 32'hABCD_4000);
        wr_cfg(2'd1, 32'h0000_0083);
        bus("R5 low nine ignored", 1'b1, 32'hABCD_41FF, 1'b1, 1'b0, 1'b1);
        bus("R5 masked bits 10:9", 1'b1, 32'hABCD_4600, 1'b1, 1'b1, 1'b1);
        bus("R5 bit11 unmasked", 1'b1, 32'hABCD_4800, 1'b1, 1'b0, 1'b0);
        bus("R5 upper exact", 1'b1, 32'hABCE_4000, 1'b1, 1'b0, 1'b0);
        bus("R1 io cycle in mem mode", 1'b1, 32'hABCD_4000, 1'b0, 1'b0, 1'b0);
        wr_cfg(2'd1, 32'h0000_80FF & 32'h0000_0080);
        bus("R6 write with bits 6:5 clear", 1'b1, 32'hABCD_4000, 1'b1, 1'b1, 1'b1);
        bus("R6 read with bits 6:5 clear", 1'b1, 32'hABCD_4000, 1'b1, 1'b0, 1'b1);
        wr_cfg(2'd3, 32'h0000_0000);
        bus("R10 select 3 ignored", 1'b1, 32'hABCD_4000, 1'b1, 1'b0, 1'b1);
    endtask

    // Wait for expiry; count falling edges from the trap pulse.
    task automatic wait_expire(input string req, input int n);
        int k = 0;
        while (!idle_expired && k < n + 10) begin
            @(negedge clk);
            k++;
        end
        check(req, k, n + 2);
        @(negedge clk);
        check("R9 expiry one clock", {31'b0, idle_expired}, 32'd0);
    endtask

    task automatic t_idle();
        wr_cfg(2'd2, 32'h0000_0005);
        repeat (12) @(negedge clk);
        bus("R9 trap for idle", 1'b1, 32'hABCD_4000, 1'b1, 1'b0, 1'b1);
        wait_expire("R9 expiry delay", 5);
        bus("R9 first trap", 1'b1, 32'hABCD_4000, 1'b1, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 no early expiry", {31'b0, idle_expired}, 32'd0);
        bus("R9 retrigger", 1'b1, 32'hABCD_4000, 1'b1, 1'b0, 1'b1);
        wait_expire("R9 restarted delay", 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_io();
        t_mem();
        t_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule